// File: doc/BRIEF.md
# Nearest-Prototype Distance Search

This block is the competition stage of a prototype-based classifier. A host first loads a set of reference vectors into the block's local store, gives each one a class label, and sets how many elements a vector has and how many prototypes are in use. After a start pulse, the block takes an input vector as a stream of beats, each beat carrying several signed 8-bit elements side by side. It then reports which stored prototype lies closest to the input, using the sum of squared element differences as the distance.

The first prototype is scored while the input streams in. The beats are also kept in a small buffer, so every later prototype is scored from that buffer at one beat per cycle. All per-element work runs in a fixed pipeline. A running minimum keeps the best prototype found so far. A single-cycle done pulse then presents the winning index, its distance and its label. The host can change the vector length and the prototype count between searches without any change to the hardware. Updating prototypes during learning is the host's job.

Top module: `proto_search`

## Requirements
- R1: The reported winner is the prototype whose sum of squared differences over the first `d` elements is smallest. `win_dist` carries that exact sum and `win_idx` its index.
- R2: Each beat carries `LANES` elements in two's complement, 8 bits each. Lane `l` of beat `b` (bits `8l+7:8l`) holds element `b*LANES+l`. Elements at positions `d` and above, in the input beat and in the stored row alike, add nothing to the distance.
- R3: The distance accumulator holds the largest possible sum without wrapping: `MAX_DIM` elements, each difference 255, give 2080800 at the default sizes.
- R4: When two prototypes have equal distance, the one with the lower index is reported.
- R5: With `B = ceil(d/LANES)` and `N` prototypes, `done` rises on the clock edge that comes `N*B + 3` edges after the edge that accepts the first input beat. This holds when the input stream has no gaps.
- R6: `in_ready` is high from the edge after `start` until exactly `B` beats have been accepted, at most one per cycle. It is low at all other times.
- R7: `done` is a one-cycle pulse. While it is high, `win_label` equals the label last written for the winning index.
- R8: Writing `cfg_dim` (1 to `MAX_DIM`) and `cfg_count` (1 to `MAX_PROTO`) with `cfg_we` sets the length and the prototype count. These values are sampled at `start` and govern that search only.
- R9: A `start` pulse is ignored while a search is still accepting or sweeping. The search under way keeps its result and its timing.
- R10: A write with `wt_we` stores `wt_data` as row `wt_row` of prototype `wt_proto`, with the lanes laid out as in R2. A write with `lbl_we` sets the label of prototype `lbl_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for length and count |
| cfg_dim | input | 6 | Vector length d |
| cfg_count | input | 4 | Number of prototypes N |
| lbl_we | input | 1 | Label write strobe |
| lbl_idx | input | 3 | Prototype whose label is written |
| lbl_val | input | 4 | Label value |
| wt_we | input | 1 | Prototype row write strobe |
| wt_proto | input | 3 | Prototype index for the row write |
| wt_row | input | 3 | Row (beat) index within the prototype |
| wt_data | input | 32 | Row contents, LANES signed words |
| start | input | 1 | Begins a search |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | 32 | Input beat, LANES signed words |
| done | output | 1 | Result pulse |
| win_idx | output | 3 | Index of the nearest prototype |
| win_dist | output | 21 | Squared distance of the winner |
| win_label | output | 4 | Label of the winner |

## Verification
The assertions take for granted that the host never writes a length or count of zero, and never writes prototype rows or labels while a search is running. The stimulus keeps to this by making every configuration and memory write between searches and by waiting for each done pulse before the next start. The stimulus also presents a gapless stream once `in_ready` rises. Pad lanes in the input beats and in the stored rows carry random data, so the masking rule is tested against non-zero values.

// File: rtl/nps_pkg.sv
package nps_pkg;
    parameter int LANES     = 4;
    parameter int WORD_W    = 8;
    parameter int MAX_DIM   = 32;
    parameter int MAX_PROTO = 8;
    parameter int LABEL_W   = 4;

    localparam int MAX_BEATS = (MAX_DIM + LANES - 1) / LANES;
    localparam int DIM_W     = $clog2(MAX_DIM + 1);
    localparam int CNT_W     = $clog2(MAX_PROTO + 1);
    localparam int IDX_W     = (MAX_PROTO > 1) ? $clog2(MAX_PROTO) : 1;
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam int NB_W      = $clog2(MAX_BEATS + 1);
    localparam int ROW_W     = LANES * WORD_W;
    localparam int DIFF_W    = WORD_W + 1;
    localparam int SQ_W      = 2 * WORD_W;
    localparam int ACC_W     = SQ_W + $clog2(MAX_DIM);
    localparam int TAIL_LAT  = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SWEEP} state_t;

    typedef struct packed {
        logic             valid;
        logic             first;
        logic             last;
        logic             final_p;
        logic [IDX_W-1:0] idx;
    } tag_t;

    function automatic logic [NB_W-1:0] beats_for(input logic [DIM_W-1:0] dim);
        return NB_W'((int'(dim) + LANES - 1) / LANES);
    endfunction
endpackage

// File: rtl/nps_store.sv
module nps_store
    import nps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [DIM_W-1:0]   cfg_dim,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               lbl_we,
    input  logic [IDX_W-1:0]   lbl_idx,
    input  logic [LABEL_W-1:0] lbl_val,
    input  logic               wt_we,
    input  logic [IDX_W-1:0]   wt_proto,
    input  logic [BEAT_W-1:0]  wt_row,
    input  logic [ROW_W-1:0]   wt_data,
    input  logic [IDX_W-1:0]   rd_proto,
    input  logic [BEAT_W-1:0]  rd_row,
    output logic [ROW_W-1:0]   rd_data,
    input  logic [IDX_W-1:0]   lbl_rd_idx,
    output logic [LABEL_W-1:0] lbl_rd,
    output logic [DIM_W-1:0]   dim_q,
    output logic [CNT_W-1:0]   cnt_q
);
    logic [ROW_W-1:0]   rows_q [MAX_PROTO*MAX_BEATS];
    logic [LABEL_W-1:0] lbl_q  [MAX_PROTO];

    always_ff @(posedge clk) begin
        if (rst) begin
            dim_q <= DIM_W'(LANES);
            cnt_q <= CNT_W'(1);
        end else if (cfg_we) begin
            dim_q <= cfg_dim;
            cnt_q <= cfg_count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_PROTO; i++) lbl_q[i] <= '0;
        end else if (lbl_we) begin
            lbl_q[lbl_idx] <= lbl_val;
        end
    end

    always_ff @(posedge clk) begin
        if (wt_we) rows_q[int'(wt_proto)*MAX_BEATS + int'(wt_row)] <= wt_data;
    end

    assign rd_data = rows_q[int'(rd_proto)*MAX_BEATS + int'(rd_row)];
    assign lbl_rd  = lbl_q[lbl_rd_idx];
endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
    import nps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_dim,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              in_valid,
    input  logic [ROW_W-1:0]  in_data,
    output logic              in_ready,
    output tag_t              iss_tag,
    output logic [ROW_W-1:0]  iss_x,
    output logic [LANES-1:0]  iss_mask,
    output logic [IDX_W-1:0]  rd_proto,
    output logic [BEAT_W-1:0] rd_row
);
    state_t            st;
    logic [DIM_W-1:0]  dim_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NB_W-1:0]   nbeats_q;
    logic [BEAT_W-1:0] beat;
    logic [IDX_W-1:0]  proto;
    logic [ROW_W-1:0]  buf_q [MAX_BEATS];

    logic accept, last_beat, last_proto;

    assign in_ready   = (st == ST_LOAD);
    assign accept     = in_ready && in_valid;
    assign last_beat  = (NB_W'(beat) + NB_W'(1)) == nbeats_q;
    assign last_proto = (CNT_W'(proto) + CNT_W'(1)) == cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            dim_q    <= '0;
            cnt_q    <= '0;
            nbeats_q <= '0;
            beat     <= '0;
            proto    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    dim_q    <= cfg_dim;
                    cnt_q    <= cfg_count;
                    nbeats_q <= beats_for(cfg_dim);
                    beat     <= '0;
                    proto    <= '0;
                    st       <= ST_LOAD;
                end
                ST_LOAD: if (in_valid) begin
                    if (last_beat) begin
                        beat <= '0;
                        if (last_proto) st <= ST_IDLE;
                        else begin
                            proto <= IDX_W'(1);
                            st    <= ST_SWEEP;
                        end
                    end else begin
                        beat <= beat + BEAT_W'(1);
                    end
                end
                ST_SWEEP: begin
                    if (last_beat) begin
                        beat <= '0;
                        if (last_proto) st <= ST_IDLE;
                        else proto <= proto + IDX_W'(1);
                    end else begin
                        beat <= beat + BEAT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) buf_q[beat] <= in_data;
    end

    always_comb begin
        iss_tag.valid   = accept || (st == ST_SWEEP);
        iss_tag.first   = (beat == '0);
        iss_tag.last    = last_beat;
        iss_tag.final_p = last_beat && last_proto;
        iss_tag.idx     = proto;
        iss_x           = (st == ST_LOAD) ? in_data : buf_q[beat];
        for (int l = 0; l < LANES; l++)
            iss_mask[l] = (int'(beat) * LANES + l) < int'(dim_q);
    end

    assign rd_proto = proto;
    assign rd_row   = beat;

    // R6: the last beat closes the input window on the next edge
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (accept && last_beat) |=> !in_ready);

    // R9: a start during a search leaves the sampled configuration alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && st != ST_IDLE) |=> ($stable(dim_q) && $stable(cnt_q)));
endmodule

// File: rtl/nps_dist_pipe.sv
module nps_dist_pipe
    import nps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tag_t             iss_tag,
    input  logic [ROW_W-1:0] iss_x,
    input  logic [ROW_W-1:0] iss_w,
    input  logic [LANES-1:0] iss_mask,
    output logic             fin_valid,
    output logic             fin_final,
    output logic [IDX_W-1:0] fin_idx,
    output logic [ACC_W-1:0] fin_sum
);
    tag_t t1, t2, t3;
    logic signed [DIFF_W-1:0] diff_q [LANES];
    logic [SQ_W-1:0]          sq_q   [LANES];
    logic [ACC_W-1:0]         beat_sum_q;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W:0]           acc_wide;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [WORD_W-1:0] xw, ww;
        logic [WORD_W-1:0]        mag;
        assign xw  = iss_x[l*WORD_W +: WORD_W];
        assign ww  = iss_w[l*WORD_W +: WORD_W];
        assign mag = diff_q[l] < 0 ? WORD_W'(-diff_q[l]) : WORD_W'(diff_q[l]);

        always_ff @(posedge clk) begin
            if (rst) begin
                diff_q[l] <= '0;
                sq_q[l]   <= '0;
            end else begin
                diff_q[l] <= iss_mask[l] ? (DIFF_W'(xw) - DIFF_W'(ww)) : '0;
                sq_q[l]   <= SQ_W'(mag) * SQ_W'(mag);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t1 <= '0;
            t2 <= '0;
            t3 <= '0;
            beat_sum_q <= '0;
        end else begin
            t1 <= iss_tag;
            t2 <= t1;
            t3 <= t2;
            beat_sum_q <= '0;
            for (int l = 0; l < LANES; l++)
                beat_sum_q <= beat_sum_q_next(l);
        end
    end

    function automatic logic [ACC_W-1:0] beat_sum_q_next(input int upto);
        logic [ACC_W-1:0] s = '0;
        for (int k = 0; k <= upto; k++) s = s + ACC_W'(sq_q[k]);
        return s;
    endfunction

    assign acc_wide = {1'b0, (t3.first ? ACC_W'(0) : acc_q)} + {1'b0, beat_sum_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            fin_valid <= 1'b0;
            fin_final <= 1'b0;
            fin_idx   <= '0;
            fin_sum   <= '0;
        end else begin
            fin_valid <= t3.valid && t3.last;
            fin_final <= t3.valid && t3.final_p;
            if (t3.valid) begin
                acc_q   <= acc_wide[ACC_W-1:0];
                fin_sum <= acc_wide[ACC_W-1:0];
                fin_idx <= t3.idx;
            end
        end
    end

    // R3: accumulation never carries past the accumulator width
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        t3.valid |-> !acc_wide[ACC_W]);
endmodule

// File: rtl/nps_min_sel.sv
module nps_min_sel
    import nps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fin_valid,
    input  logic               fin_final,
    input  logic [IDX_W-1:0]   fin_idx,
    input  logic [ACC_W-1:0]   fin_sum,
    output logic [IDX_W-1:0]   cand_idx,
    input  logic [LABEL_W-1:0] cand_label,
    output logic               done,
    output logic [IDX_W-1:0]   win_idx,
    output logic [ACC_W-1:0]   win_dist,
    output logic [LABEL_W-1:0] win_label
);
    logic [IDX_W-1:0] best_idx;
    logic [ACC_W-1:0] best_dist, cand_dist;
    logic             take;

    assign take      = fin_valid && ((fin_idx == '0) || (fin_sum < best_dist));
    assign cand_idx  = take ? fin_idx : best_idx;
    assign cand_dist = take ? fin_sum : best_dist;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_idx  <= '0;
            best_dist <= '0;
            done      <= 1'b0;
            win_idx   <= '0;
            win_dist  <= '0;
            win_label <= '0;
        end else begin
            best_idx  <= cand_idx;
            best_dist <= cand_dist;
            done      <= fin_valid && fin_final;
            if (fin_valid && fin_final) begin
                win_idx   <= cand_idx;
                win_dist  <= cand_dist;
                win_label <= cand_label;
            end
        end
    end

    // R1: the running minimum never grows within a search
    a_r1_running_min: assert property (@(posedge clk) disable iff (rst)
        (fin_valid && fin_idx != '0) |=> (best_dist <= $past(best_dist)));

    // R4: an equal later distance does not displace the earlier winner
    a_r4_tie_keeps_lower: assert property (@(posedge clk) disable iff (rst)
        (fin_valid && fin_idx != '0 && fin_sum == best_dist) |=> (best_idx == $past(best_idx)));

    // R7: result strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/proto_search.sv
module proto_search
    import nps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [DIM_W-1:0]   cfg_dim,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               lbl_we,
    input  logic [IDX_W-1:0]   lbl_idx,
    input  logic [LABEL_W-1:0] lbl_val,
    input  logic               wt_we,
    input  logic [IDX_W-1:0]   wt_proto,
    input  logic [BEAT_W-1:0]  wt_row,
    input  logic [ROW_W-1:0]   wt_data,
    input  logic               start,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ROW_W-1:0]   in_data,
    output logic               done,
    output logic [IDX_W-1:0]   win_idx,
    output logic [ACC_W-1:0]   win_dist,
    output logic [LABEL_W-1:0] win_label
);
    logic [DIM_W-1:0]   dim_cfg;
    logic [CNT_W-1:0]   cnt_cfg;
    logic [IDX_W-1:0]   rd_proto, cand_idx, fin_idx;
    logic [BEAT_W-1:0]  rd_row;
    logic [ROW_W-1:0]   rd_data, iss_x;
    logic [LANES-1:0]   iss_mask;
    logic [LABEL_W-1:0] cand_label;
    logic [ACC_W-1:0]   fin_sum;
    logic               fin_valid, fin_final;
    tag_t               iss_tag;

    nps_store u_store (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_dim(cfg_dim), .cfg_count(cfg_count),
        .lbl_we(lbl_we), .lbl_idx(lbl_idx), .lbl_val(lbl_val),
        .wt_we(wt_we), .wt_proto(wt_proto), .wt_row(wt_row), .wt_data(wt_data),
        .rd_proto(rd_proto), .rd_row(rd_row), .rd_data(rd_data),
        .lbl_rd_idx(cand_idx), .lbl_rd(cand_label),
        .dim_q(dim_cfg), .cnt_q(cnt_cfg)
    );

    nps_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .cfg_dim(dim_cfg), .cfg_count(cnt_cfg),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .iss_tag(iss_tag), .iss_x(iss_x), .iss_mask(iss_mask),
        .rd_proto(rd_proto), .rd_row(rd_row)
    );

    nps_dist_pipe u_pipe (
        .clk(clk), .rst(rst),
        .iss_tag(iss_tag), .iss_x(iss_x), .iss_w(rd_data), .iss_mask(iss_mask),
        .fin_valid(fin_valid), .fin_final(fin_final), .fin_idx(fin_idx), .fin_sum(fin_sum)
    );

    nps_min_sel u_min (
        .clk(clk), .rst(rst),
        .fin_valid(fin_valid), .fin_final(fin_final), .fin_idx(fin_idx), .fin_sum(fin_sum),
        .cand_idx(cand_idx), .cand_label(cand_label),
        .done(done), .win_idx(win_idx), .win_dist(win_dist), .win_label(win_label)
    );
endmodule

// File: tb/sim_proto_search.sv
module sim_proto_search;
    import nps_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, lbl_we = 0, wt_we = 0, start = 0, in_valid = 0;
    logic [DIM_W-1:0]   cfg_dim = '0;
    logic [CNT_W-1:0]   cfg_count = '0;
    logic [IDX_W-1:0]   lbl_idx = '0, wt_proto = '0;
    logic [LABEL_W-1:0] lbl_val = '0;
    logic [BEAT_W-1:0]  wt_row = '0;
    logic [ROW_W-1:0]   wt_data = '0, in_data = '0;
    logic               in_ready, done;
    logic [IDX_W-1:0]   win_idx;
    logic [ACC_W-1:0]   win_dist;
    logic [LABEL_W-1:0] win_label;

    int n_checks = 0, n_errors = 0, cyc = 0;
    int W [MAX_PROTO][MAX_DIM];
    int X [MAX_DIM];
    int LBL [MAX_PROTO];
    int got_idx, got_dist, got_lbl, got_lat, exp_idx, exp_dist;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    proto_search u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic write_protos();
        for (int p = 0; p < MAX_PROTO; p++) begin
            for (int r = 0; r < MAX_BEATS; r++) begin
                @(negedge clk);
                wt_we = 1; wt_proto = IDX_W'(p); wt_row = BEAT_W'(r);
                for (int l = 0; l < LANES; l++)
                    wt_data[l*WORD_W +: WORD_W] = WORD_W'(W[p][r*LANES+l]);
            end
            @(negedge clk);
            wt_we = 0; lbl_we = 1; lbl_idx = IDX_W'(p); lbl_val = LABEL_W'(LBL[p]);
        end
        @(negedge clk);
        lbl_we = 0;
    endtask

    task automatic randomize_all();
        for (int p = 0; p < MAX_PROTO; p++) begin
            for (int e = 0; e < MAX_DIM; e++) W[p][e] = rnd8();
            LBL[p] = int'($urandom_range(15));
        end
        for (int e = 0; e < MAX_DIM; e++) X[e] = rnd8();
    endtask

    function automatic void model(input int d, input int n);
        exp_dist = -1;
        exp_idx = 0;
        for (int p = 0; p < n; p++) begin
            int s = 0;
            for (int e = 0; e < d; e++) s += (X[e] - W[p][e]) * (X[e] - W[p][e]);
            if (exp_dist < 0 || s < exp_dist) begin
                exp_dist = s;
                exp_idx = p;
            end
        end
    endfunction

    // Runs one search and checks R1, R5, R6, R7 on it
    task automatic run_search(input int d, input int n, input bit mid_start);
        int nb, t0;
        bit seen;
        nb = (d + LANES - 1) / LANES;
        @(negedge clk);
        cfg_we = 1; cfg_dim = DIM_W'(d); cfg_count = CNT_W'(n);
        @(negedge clk);
        cfg_we = 0; start = 1;
        @(negedge clk);
        start = 0;
        t0 = 0;
        for (int b = 0; b < nb; b++) begin
            check(in_ready == 1'b1, "R6 ready while loading", int'(in_ready), 1);
            in_valid = 1;
            start = (mid_start && b == 1);
            for (int l = 0; l < LANES; l++)
                in_data[l*WORD_W +: WORD_W] = WORD_W'(X[(b*LANES+l) % MAX_DIM]);
            @(negedge clk);
            if (b == 0) t0 = cyc;
        end
        in_valid = 0; start = 0; in_data = '1;
        check(in_ready == 1'b0, "R6 ready low after last beat", int'(in_ready), 0);
        seen = 0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        got_lat = cyc - t0;
        got_idx = int'(win_idx);
        got_dist = int'(win_dist);
        got_lbl = int'(win_label);
        model(d, n);
        check(seen, "R7 done seen", int'(seen), 1);
        check(got_idx == exp_idx, "R1 winner index", got_idx, exp_idx);
        check(got_dist == exp_dist, "R1 winner distance", got_dist, exp_dist);
        check(got_lbl == LBL[exp_idx], "R7 winner label", got_lbl, LBL[exp_idx]);
        check(got_lat == n*nb + TAIL_LAT, "R5 latency", got_lat, n*nb + TAIL_LAT);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R7 reset done", int'(done), 0);
        check(in_ready == 1'b0, "R6 reset ready", int'(in_ready), 0);
        check(win_dist == '0, "R1 reset distance", int'(win_dist), 0);
    endtask

    task automatic t_basic();
        randomize_all();
        write_protos();
        run_search(8, 4, 0);
        check(got_dist == exp_dist, "R10 row layout", got_dist, exp_dist);
    endtask

    task automatic t_pad();
        randomize_all();
        write_protos();
        run_search(5, 3, 0);
        check(got_dist == exp_dist, "R2 pad lanes masked", got_dist, exp_dist);
        run_search(11, 5, 0);
        check(got_dist == exp_dist, "R2 pad lanes masked d=11", got_dist, exp_dist);
    endtask

    task automatic t_reconfig();
        run_search(1, 1, 0);
        check(got_lat == 1 + TAIL_LAT, "R8 small config", got_lat, 1 + TAIL_LAT);
        run_search(MAX_DIM, MAX_PROTO, 0);
        check(got_lat == MAX_PROTO*MAX_BEATS + TAIL_LAT, "R8 full config", got_lat,
              MAX_PROTO*MAX_BEATS + TAIL_LAT);
    endtask

    task automatic t_overflow();
        for (int e = 0; e < MAX_DIM; e++) begin
            X[e] = 127;
            W[0][e] = -128;
        end
        write_protos();
        run_search(MAX_DIM, 1, 0);
        check(got_dist == MAX_DIM*255*255, "R3 max distance", got_dist, MAX_DIM*255*255);
    endtask

    task automatic t_tie();
        randomize_all();
        for (int e = 0; e < MAX_DIM; e++) begin
            W[2][e] = (X[e] > 0) ? X[e] - 1 : X[e] + 1;
            W[5][e] = W[2][e];
        end
        write_protos();
        run_search(7, 6, 0);
        check(got_idx == 2, "R4 tie goes to lower index", got_idx, 2);
    endtask

    task automatic t_mid_start();
        randomize_all();
        write_protos();
        run_search(12, 3, 1);
        check(got_lat == 3*3 + TAIL_LAT, "R9 start mid-search ignored", got_lat, 3*3 + TAIL_LAT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pad();
        t_reconfig();
        t_overflow();
        t_tie();
        t_mid_start();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule